// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs one DMA channel in link mode. Software writes a ring of eight-word descriptors into memory and loads the channel's next-link address. It then pulses the enable input. From that point the block walks the chain on its own. For each descriptor it reads the header word and checks the valid flag. It then reads the remaining words over a one-outstanding read port and hands source, destination, byte count and configuration to an external data mover. When the mover reports done, it writes the header back as zero and follows the next-link word to the next descriptor.

The walk ends quietly at the first descriptor whose valid flag is clear. Each descriptor's configuration word travels with its own transfer. A mask bit in that word decides whether the transfer's end raises a one-cycle end event. Two things stop the walk early. A read returned with an error sets a sticky error flag and stops the engine. A soft reset makes the engine drop back to idle at the next safe point: after an outstanding read response, after the mover finishes, or after a pending write is acknowledged.

The controller has six states. IDLE waits for enable. FETCH reads descriptor words. LAUNCH issues the mover start. MOVE waits for done. WBACK writes the cleared header. NEXT loads the next-link address. The transitions are:
- IDLE to FETCH on enable.
- FETCH to IDLE on an invalid header, an error response or an abort.
- FETCH to LAUNCH after the eighth word.
- LAUNCH to MOVE.
- MOVE to WBACK on done.
- WBACK to NEXT on write acknowledge.
- NEXT to FETCH.
- LAUNCH, MOVE, WBACK and NEXT fall to IDLE instead when an abort is pending.

Top module: `lnk_chain_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, `rd_req`, `wr_req`, `mv_start`, `end_evt` and `err_flag` are low (err_flag until an error occurs).
- R2: An enable pulse while idle starts fetching at `link_addr`. Word k of a descriptor is read at base + 4*k, for k = 0..7 in ascending order. Each `rd_req` is held with a stable address until `rd_rvalid`.
- R3: Header bit 0 is the valid flag. If it is 0, the engine reads no further word, starts no transfer, raises no end event and no error, does not write that header, and returns to idle. The other header bits are ignored.
- R4: Each valid descriptor produces exactly one single-cycle `mv_start`. With it come `mv_src` = word 1, `mv_dst` = word 2, `mv_len` = word 3 and `mv_cfg` = word 4 of that descriptor.
- R5: After `mv_done`, the engine writes 0 to the descriptor's header address (its base). `wr_req` is held with a stable address until `wr_ack`.
- R6: `end_evt` pulses for one cycle, in the cycle after the header write is acknowledged, only when bit 24 of the descriptor's configuration word is 0.
- R7: The next descriptor is fetched from the address held in word 7, so a chain can wrap from the last ring slot back to the first.
- R8: A read response with `rd_rerr` set stops the engine: no further reads, no mover start, `err_flag` high, `busy` low. The next accepted enable clears `err_flag`.
- R9: A soft reset while a transfer is in flight lets the mover finish. After that there is no header write and no end event, and the engine returns to idle.
- R10: A soft reset during a fetch waits for the outstanding read response, then returns to idle without starting a transfer.
- R11: An enable pulse while the engine is busy has no effect on the addresses it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | 1 | Start pulse, accepted only when idle |
| soft_reset | input | 1 | Abort request, honoured at the next safe point |
| link_addr | input | WORD_W | Byte address of the first descriptor |
| rd_req | output | 1 | Read request, held until response |
| rd_addr | output | WORD_W | Read byte address |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | WORD_W | Read response data |
| rd_rerr | input | 1 | Read response error |
| wr_req | output | 1 | Header write-back request, held until ack |
| wr_addr | output | WORD_W | Write byte address |
| wr_data | output | WORD_W | Write data (cleared header) |
| wr_ack | input | 1 | Write acknowledge |
| mv_start | output | 1 | Single-cycle transfer start to the data mover |
| mv_src | output | WORD_W | Transfer source address |
| mv_dst | output | WORD_W | Transfer destination address |
| mv_len | output | WORD_W | Transfer byte count |
| mv_cfg | output | WORD_W | Per-descriptor configuration word |
| mv_done | input | 1 | Data mover completion pulse |
| busy | output | 1 | Engine not idle |
| end_evt | output | 1 | Single-cycle end event |
| err_flag | output | 1 | Sticky fetch error flag |

## Verification
The main walk is swept over chain lengths 0 to 5, read latencies 0 to 2 and several mover latencies. The start slot and the end-mask pattern change with each run. Length 0 isolates the invalid-header stop. Differing latencies show whether the handshakes hold their request. The mask patterns tell a suppressed end event from a missing one. A chain that starts at slot 62 shows whether the link word, and not an address increment, picks the next descriptor. Separate runs place a read error in the middle of the second descriptor, a soft reset inside a long transfer, a soft reset during a slow read, and a second enable during a walk. Each of these has its own expected read, write and start counts.

// File: rtl/lce_pkg.sv
`timescale 1ns/1ps
package lce_pkg;
    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // word positions inside one descriptor
    localparam int W_HDR = 0;
    localparam int W_SRC = 1;
    localparam int W_DST = 2;
    localparam int W_CNT = 3;
    localparam int W_CFG = 4;
    localparam int W_NXT = 7;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_MOVE   = 3'd3,
        ST_WBACK  = 3'd4,
        ST_NEXT   = 3'd5
    } lce_state_e;
endpackage

// File: rtl/lce_fsm.sv
`timescale 1ns/1ps
module lce_fsm
    import lce_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    input  logic             hdr_valid,
    input  logic [IDX_W-1:0] word_idx,
    input  logic             mv_done,
    input  logic             wr_ack,
    output lce_state_e       state_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    lce_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (rsp_valid) begin
                    if (abort || rsp_err)
                        state_d = ST_IDLE;
                    else if ((word_idx == '0) && !hdr_valid)
                        state_d = ST_IDLE;
                    else if (word_idx == LAST_IDX)
                        state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: state_d = abort ? ST_IDLE : ST_MOVE;
            ST_MOVE: begin
                if (mv_done) state_d = abort ? ST_IDLE : ST_WBACK;
            end
            ST_WBACK: begin
                if (wr_ack) state_d = abort ? ST_IDLE : ST_NEXT;
            end
            ST_NEXT: state_d = abort ? ST_IDLE : ST_FETCH;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/lce_addr_unit.sv
`timescale 1ns/1ps
module lce_addr_unit
    import lce_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic [WORD_W-1:0] start_addr,
    input  logic              load_next,
    input  logic [WORD_W-1:0] next_addr,
    input  logic              step,
    output logic [WORD_W-1:0] base_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [WORD_W-1:0] word_addr
);
    localparam int BYTE_SH = $clog2(WORD_W / 8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load_start) begin
            base_q <= start_addr;
            idx_q  <= '0;
        end else if (load_next) begin
            base_q <= next_addr;
            idx_q  <= '0;
        end else if (step) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    assign word_addr = base_q + (WORD_W'(idx_q) << BYTE_SH);
endmodule

// File: rtl/lce_desc_capture.sv
`timescale 1ns/1ps
module lce_desc_capture
    import lce_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_data,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] dst_o,
    output logic [WORD_W-1:0] cnt_o,
    output logic [WORD_W-1:0] cfg_o,
    output logic [WORD_W-1:0] nxt_o
);
    localparam int N_KEEP = 5;

    function automatic int keep_word(input int k);
        case (k)
            0:       return W_SRC;
            1:       return W_DST;
            2:       return W_CNT;
            3:       return W_CFG;
            default: return W_NXT;
        endcase
    endfunction

    for (genvar k = 0; k < N_KEEP; k++) begin : g_word
        localparam int WPOS = keep_word(k);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (cap_en && (cap_idx == IDX_W'(WPOS)))
                q <= cap_data;
        end
    end

    assign src_o = g_word[0].q;
    assign dst_o = g_word[1].q;
    assign cnt_o = g_word[2].q;
    assign cfg_o = g_word[3].q;
    assign nxt_o = g_word[4].q;
endmodule

// File: rtl/lnk_chain_engine.sv
`timescale 1ns/1ps
module lnk_chain_engine
    import lce_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int VALID_BIT    = 0,
    parameter int END_MASK_BIT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_enable,
    input  logic              soft_reset,
    input  logic [WORD_W-1:0] link_addr,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_rvalid,
    input  logic [WORD_W-1:0] rd_rdata,
    input  logic              rd_rerr,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              mv_start,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    output logic [WORD_W-1:0] mv_len,
    output logic [WORD_W-1:0] mv_cfg,
    input  logic              mv_done,
    output logic              busy,
    output logic              end_evt,
    output logic              err_flag
);
    lce_state_e        state_q;
    logic              go, abort, abort_pend, step, load_next;
    logic [WORD_W-1:0] base_q, word_addr, nxt_w;
    logic [IDX_W-1:0]  idx_q;
    logic              start_q, end_q, err_q;

    assign go        = ch_enable && !soft_reset && (state_q == ST_IDLE);
    assign abort     = soft_reset || abort_pend;
    assign step      = (state_q == ST_FETCH) && rd_rvalid;
    assign load_next = (state_q == ST_NEXT);

    lce_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .abort     (abort),
        .rsp_valid (step),
        .rsp_err   (rd_rerr),
        .hdr_valid (rd_rdata[VALID_BIT]),
        .word_idx  (idx_q),
        .mv_done   (mv_done),
        .wr_ack    (wr_ack),
        .state_q   (state_q)
    );

    lce_addr_unit #(.WORD_W(WORD_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (go),
        .start_addr (link_addr),
        .load_next  (load_next),
        .next_addr  (nxt_w),
        .step       (step),
        .base_q     (base_q),
        .idx_q      (idx_q),
        .word_addr  (word_addr)
    );

    lce_desc_capture #(.WORD_W(WORD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (step),
        .cap_idx  (idx_q),
        .cap_data (rd_rdata),
        .src_o    (mv_src),
        .dst_o    (mv_dst),
        .cnt_o    (mv_len),
        .cfg_o    (mv_cfg),
        .nxt_o    (nxt_w)
    );

    // pending abort: latched while active, dropped once idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  abort_pend <= 1'b0;
        else if (state_q == ST_IDLE) abort_pend <= 1'b0;
        else if (soft_reset)         abort_pend <= 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            end_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            start_q <= (state_q == ST_LAUNCH) && !abort;
            end_q   <= (state_q == ST_WBACK) && wr_ack && !abort
                       && !mv_cfg[END_MASK_BIT];
            if (go)                  err_q <= 1'b0;
            else if (step && rd_rerr) err_q <= 1'b1;
        end
    end

    assign rd_req   = (state_q == ST_FETCH);
    assign rd_addr  = word_addr;
    assign wr_req   = (state_q == ST_WBACK);
    assign wr_addr  = base_q;
    assign wr_data  = '0;
    assign mv_start = start_q;
    assign end_evt  = end_q;
    assign err_flag = err_q;
    assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/lnk_chain_engine_chk.sv
`timescale 1ns/1ps
module lnk_chain_engine_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [WORD_W-1:0] rd_addr,
    input logic              rd_rvalid,
    input logic              rd_rerr,
    input logic              wr_req,
    input logic [WORD_W-1:0] wr_addr,
    input logic              wr_ack,
    input logic              mv_start,
    input logic              busy,
    input logic              end_evt,
    input logic              err_flag
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req && !mv_start));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_rvalid) |=> (rd_req && $stable(rd_addr)));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |=> !mv_start);

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));

    // R6
    end_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |-> $past(wr_req && wr_ack));

    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_rvalid && rd_rerr) |=> (err_flag && !busy));
endmodule

bind lnk_chain_engine lnk_chain_engine_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_rvalid (rd_rvalid),
    .rd_rerr   (rd_rerr),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_ack    (wr_ack),
    .mv_start  (mv_start),
    .busy      (busy),
    .end_evt   (end_evt),
    .err_flag  (err_flag)
);

// File: tb/lnk_chain_engine_tb_top.sv
`timescale 1ns/1ps
module lnk_chain_engine_tb_top;
    localparam logic [31:0] RING_BASE = 32'h0000_8000;
    localparam logic [31:0] CFG_COPY  = 32'h8040_0008;
    localparam logic [31:0] BAD_HDR   = 32'hFFFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_enable = 1'b0;
    logic        soft_reset = 1'b0;
    logic [31:0] link_addr = '0;
    logic        rd_req, wr_req, mv_start, busy, end_evt, err_flag;
    logic [31:0] rd_addr, wr_addr, wr_data, mv_src, mv_dst, mv_len, mv_cfg;
    logic        rd_rvalid = 1'b0, rd_rerr = 1'b0, wr_ack = 1'b0, mv_done = 1'b0;
    logic [31:0] rd_rdata = '0;

    always #2.5 clk = ~clk;

    lnk_chain_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .soft_reset(soft_reset),
        .link_addr(link_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .rd_rerr(rd_rerr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
        .mv_cfg(mv_cfg), .mv_done(mv_done), .busy(busy), .end_evt(end_evt),
        .err_flag(err_flag)
    );

    logic [31:0] mem [0:511];
    logic [31:0] rd_log [0:127];
    logic [31:0] s_src [0:15];
    logic [31:0] s_dst [0:15];
    logic [31:0] s_len [0:15];
    logic [31:0] s_cfg [0:15];
    int rd_cnt = 0, wr_cnt = 0, st_cnt = 0, end_cnt = 0;
    int rd_lat = 0, mv_lat = 0, wr_lat = 1;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    function automatic logic [31:0] slot_addr(input int s);
        return RING_BASE + 32'(s * 32);
    endfunction

    function automatic int midx(input logic [31:0] a);
        return int'(((a - RING_BASE) >> 2) & 32'h1FF);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // read responder
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            if (rd_rvalid) begin
                rd_rvalid = 1'b0;
                rd_rerr   = 1'b0;
            end else if (rd_req) begin
                if (w >= rd_lat) begin
                    rd_rvalid = 1'b1;
                    rd_rdata  = mem[midx(rd_addr)];
                    rd_rerr   = (rd_addr == err_addr);
                    if (rd_cnt < 128) rd_log[rd_cnt] = rd_addr;
                    rd_cnt++;
                    w = 0;
                end else w++;
            end else w = 0;
        end
    end

    // write responder
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            if (wr_ack) wr_ack = 1'b0;
            else if (wr_req) begin
                if (w >= wr_lat) begin
                    wr_ack = 1'b1;
                    mem[midx(wr_addr)] = wr_data;
                    wr_cnt++;
                    w = 0;
                end else w++;
            end else w = 0;
        end
    end

    // data mover model and end-event monitor
    initial begin
        int w = 0;
        bit act = 1'b0;
        forever begin
            @(negedge clk);
            if (end_evt) end_cnt++;
            if (mv_done) mv_done = 1'b0;
            if (mv_start) begin
                if (st_cnt < 16) begin
                    s_src[st_cnt] = mv_src; s_dst[st_cnt] = mv_dst;
                    s_len[st_cnt] = mv_len; s_cfg[st_cnt] = mv_cfg;
                end
                st_cnt++;
                act = 1'b1;
                w = 0;
            end else if (act) begin
                if (w >= mv_lat) begin
                    mv_done = 1'b1;
                    act = 1'b0;
                end else w++;
            end
        end
    end

    function automatic logic [31:0] exp_cfg(input int i, input int n, input int pat);
        return CFG_COPY | (((i < n - 1) && (((pat >> i) & 1) == 1)) ? 32'h0100_0000 : 32'h0);
    endfunction

    task automatic build(input int b, input int n, input int pat);
        for (int i = 0; i < 512; i++) mem[i] = '0;
        for (int i = 0; i < n; i++) begin
            int s = (b + i) % 64;
            mem[s*8+0] = 32'hA5A5_0001;
            mem[s*8+1] = 32'h1000_0000 + 32'(s * 16);
            mem[s*8+2] = 32'h2000_0000 + 32'(s * 64);
            mem[s*8+3] = 32'(s * 4 + 7);
            mem[s*8+4] = exp_cfg(i, n, pat);
            mem[s*8+5] = 32'h55;
            mem[s*8+6] = 32'h66;
            mem[s*8+7] = slot_addr((s + 1) % 64);
        end
        mem[((b + n) % 64) * 8] = BAD_HDR;
    endtask

    task automatic clear_counts();
        rd_cnt = 0; wr_cnt = 0; st_cnt = 0; end_cnt = 0;
    endtask

    task automatic pulse_enable(input logic [31:0] a);
        @(negedge clk);
        link_addr = a;
        ch_enable = 1'b1;
        @(negedge clk);
        ch_enable = 1'b0;
    endtask

    task automatic pulse_soft_reset();
        @(negedge clk);
        soft_reset = 1'b1;
        @(negedge clk);
        soft_reset = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_chain(input int b, input int n, input int pat, input int rl,
                             input int ml, input bit dup_en);
        int bad, exp_end, exp_rd;
        build(b, n, pat);
        rd_lat = rl; mv_lat = ml;
        clear_counts();
        pulse_enable(slot_addr(b));
        if (dup_en) begin
            repeat (4) @(negedge clk);
            pulse_enable(slot_addr(50));
        end
        wait_idle();
        // R4 one start per valid descriptor
        chk(st_cnt == n, "R4 start count", 32'(st_cnt), 32'(n));
        bad = 0;
        for (int i = 0; i < n && i < 16; i++) begin
            int s = (b + i) % 64;
            if (s_src[i] != 32'h1000_0000 + 32'(s * 16) || s_dst[i] != 32'h2000_0000 + 32'(s * 64)
                || s_len[i] != 32'(s * 4 + 7) || s_cfg[i] != exp_cfg(i, n, pat)) bad++;
        end
        chk(bad == 0, "R4 mover fields", 32'(bad), 0);
        // R3 stop after invalid header: 8 words per descriptor plus one header
        exp_rd = 8 * n + 1;
        chk(rd_cnt == exp_rd, "R3 read count", 32'(rd_cnt), 32'(exp_rd));
        bad = 0;
        for (int j = 0; j < exp_rd && j < 128; j++) begin
            logic [31:0] e = slot_addr((b + j / 8) % 64) + 32'((j % 8) * 4);
            if (rd_log[j] != e) bad++;
        end
        // R2 word order, R7 link following, R11 second enable ignored
        chk(bad == 0, dup_en ? "R11 R2 R7 read order" : "R2 R7 read order", 32'(bad), 0);
        chk(wr_cnt == n, "R5 write count", 32'(wr_cnt), 32'(n));
        bad = 0;
        for (int i = 0; i < n; i++) if (mem[((b + i) % 64) * 8] != 0) bad++;
        chk(bad == 0, "R5 headers cleared", 32'(bad), 0);
        chk(mem[((b + n) % 64) * 8] == BAD_HDR, "R3 invalid header untouched",
            mem[((b + n) % 64) * 8], BAD_HDR);
        exp_end = 0;
        for (int i = 0; i < n; i++) if (exp_cfg(i, n, pat) == CFG_COPY) exp_end++;
        chk(end_cnt == exp_end, "R6 end events", 32'(end_cnt), 32'(exp_end));
        chk(!err_flag && !busy, "R3 quiet stop", {30'd0, err_flag, busy}, 0);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({busy, rd_req, wr_req, mv_start, end_evt, err_flag} == 6'b0, "R1 reset outputs",
            {26'd0, busy, rd_req, wr_req, mv_start, end_evt, err_flag}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !rd_req, "R1 idle after reset", {30'd0, busy, rd_req}, 0);

        // sweep of chain length, latencies and mask patterns
        for (int n = 0; n <= 5; n++)
            for (int rl = 0; rl <= 2; rl++)
                run_chain((n * 13 + rl * 7) % 64, n, n * 5 + rl, rl, rl + (n % 2), 1'b0);
        // R7 ring wrap from slot 63 to slot 0
        run_chain(62, 4, 5, 1, 1, 1'b0);
        // R11 enable during a walk
        run_chain(7, 3, 2, 2, 3, 1'b1);

        // R8 read error in the second descriptor's word 3
        build(10, 3, 0);
        rd_lat = 0; mv_lat = 1;
        err_addr = slot_addr(11) + 12;
        clear_counts();
        pulse_enable(slot_addr(10));
        wait_idle();
        chk(err_flag == 1'b1, "R8 error flag set", {31'd0, err_flag}, 1);
        chk(st_cnt == 1, "R8 no start after error", 32'(st_cnt), 1);
        chk(rd_cnt == 12, "R8 reads stop", 32'(rd_cnt), 12);
        chk(!busy, "R8 idle after error", {31'd0, busy}, 0);
        err_addr = 32'hFFFF_FFFF;
        build(10, 1, 0);
        clear_counts();
        pulse_enable(slot_addr(10));
        chk(err_flag == 1'b0, "R8 error cleared by enable", {31'd0, err_flag}, 0);
        wait_idle();
        chk(st_cnt == 1 && !err_flag, "R8 clean run after error", 32'(st_cnt), 1);

        // R9 soft reset during a transfer
        build(20, 2, 0);
        rd_lat = 0; mv_lat = 20;
        clear_counts();
        pulse_enable(slot_addr(20));
        begin
            int g = 0;
            while (st_cnt == 0 && g < 1000) begin @(negedge clk); g++; end
        end
        pulse_soft_reset();
        wait_idle();
        chk(st_cnt == 1, "R9 single start", 32'(st_cnt), 1);
        chk(wr_cnt == 0, "R9 no header write", 32'(wr_cnt), 0);
        chk(end_cnt == 0, "R9 no end event", 32'(end_cnt), 0);
        chk(mem[20*8] == 32'hA5A5_0001, "R9 header still valid", mem[20*8], 32'hA5A5_0001);
        chk(!busy, "R9 idle", {31'd0, busy}, 0);

        // R10 soft reset during a slow fetch
        build(30, 2, 0);
        rd_lat = 6; mv_lat = 1;
        clear_counts();
        pulse_enable(slot_addr(30));
        @(negedge clk);
        pulse_soft_reset();
        wait_idle();
        chk(rd_cnt == 1, "R10 outstanding read completes only", 32'(rd_cnt), 1);
        chk(st_cnt == 0, "R10 no start", 32'(st_cnt), 0);
        chk(!busy && !err_flag, "R10 idle", {30'd0, busy, err_flag}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule